// File: doc/BRIEF.md
# Two-Line Clause-22 Management Master

This block is a serial management master that issues clause-22 read and write frames to one of two transceivers. Each transceiver hangs on its own data line (an on-board one and a plug-in one), while a single management clock is shared. The pad is not part of the block: each line is presented as a separate output value, output enable and input sample.

When reset is released, the block runs a preamble and then a presence probe. The probe releases both lines, gives the clock one pulse and samples both lines. The transceiver it finds is used for every later frame, at a fixed bus address that is a parameter for each line. A host asks for a frame by pulsing `reqValid` while `busy` is low, giving the direction, the 5-bit register number and, for writes, 16 data bits. The block answers with a one-cycle `done` and, for reads, the 16-bit result. When no transceiver was found, a request completes at once and is flagged invalid.

The clock runs at the system clock divided by `CLK_DIV`. Each bit occupies one slot of `CLK_DIV` system cycles: the clock is low for the first `CLK_DIV/2` cycles and high for the rest. Data lines change only at the start of a slot.

Top module: `mdio_dual_master`

## Requirements
- R1: From reset release, the block is busy for 20 slots with both lines driven high and enabled, then one probe slot with both lines released (enable low, value 1) and one clock pulse. Requests during this time are ignored.
- R2: At the end of the probe slot, a high plug-in line selects it (`portExt`=1, `noTcvr`=0). Otherwise a high on-board line selects the on-board one (`portExt`=0, `noTcvr`=0). Otherwise `noTcvr`=1 and `portExt`=0. Priority goes to the plug-in line.
- R3: `mdc` is low in the first `CLK_DIV/2` cycles of every slot and high in the remaining cycles. It is low whenever the block is not busy.
- R4: Every accepted frame starts with 20 slots in which both lines are driven high with their enables on.
- R5: After the preamble, a read drives 14 bits on the selected line, MSB first: 0,1,1,0, then the selected line's 5-bit bus address, then the 5-bit register number.
- R6: After the preamble, a write drives 32 bits on the selected line, MSB first: 0,1,0,1, the 5-bit bus address, the 5-bit register number, 1,0, then the 16 data bits.
- R7: A read releases the selected line for 21 slots. The bits present in slots 16 to 31 after the preamble form the result, MSB first. The plug-in line is sampled in the last low-clock cycle of a slot; the on-board line is sampled in the last high-clock cycle.
- R8: Any line that is not being driven has its enable low and its output value at 1. During a frame, the unselected line is never driven after the preamble.
- R9: `done` is high for exactly one cycle, in the cycle after the last slot of a frame, and `busy` is already low in that cycle. `rdData` changes only together with `done`. Writes leave `rdData` unchanged.
- R10: With `noTcvr`=1, a request gives `done`=1 and `invalid`=1 in the next cycle, with `rdData`=16'hFFFF, and the lines do not move.
- R11: A request made while `busy` is high is ignored and never starts a second frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Frame request pulse, taken when `busy` is low |
| reqWrite | input | 1 | 1 = write frame, 0 = read frame |
| reqReg | input | 5 | Register number inside the transceiver |
| reqData | input | 16 | Write data |
| busy | output | 1 | Preamble, probe or frame in progress |
| done | output | 1 | One-cycle completion pulse |
| invalid | output | 1 | With `done`: request refused, no transceiver |
| rdData | output | 16 | Last read result |
| portExt | output | 1 | 1 = plug-in transceiver selected |
| noTcvr | output | 1 | Probe found no transceiver |
| mdc | output | 1 | Shared management clock |
| intMdi | input | 1 | On-board line sampled value |
| intMdo | output | 1 | On-board line drive value |
| intMdoEn | output | 1 | On-board line drive enable |
| extMdi | input | 1 | Plug-in line sampled value |
| extMdo | output | 1 | Plug-in line drive value |
| extMdoEn | output | 1 | Plug-in line drive enable |

## Verification
The bench builds the block with `CLK_DIV`=6, on-board bus address 5'h13 and plug-in bus address 5'h0A. A divider above the minimum gives each clock half three cycles, so sampling one cycle early or late is detectable. The bench's transceiver model puts the correct read bit only in the half-slot where the selected line is meant to be sampled, and puts the inverted bit in the other half. The two distinct non-zero bus addresses make a swap between lines visible in the driven header. Three resets with different probe levels cover both presence priorities and the absent case.

// File: rtl/mdio_dm_pkg.sv
package mdio_dm_pkg;

  localparam int PRE_SLOTS     = 20;
  localparam int WR_SLOTS      = 32;
  localparam int RD_SLOTS      = 35;
  localparam int RD_HDR_SLOTS  = 14;
  localparam int RD_DATA_FIRST = 16;
  localparam int DATA_BITS     = 16;
  localparam int SLOT_W        = 6;

  typedef enum logic [1:0] {
    ST_PRE  = 2'd0,
    ST_DET  = 2'd1,
    ST_RDY  = 2'd2,
    ST_BITS = 2'd3
  } ctrlState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadFrame;
    logic shiftTx;
    logic sampleRx;
    logic sampleDet;
    logic finishRd;
    logic finishBad;
    logic driveBoth;
    logic driveAct;
  } strobe_t;

endpackage

// File: rtl/mdio_dm_ctrl.sv
module mdio_dm_ctrl
  import mdio_dm_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    noTcvr,
  input  logic    portExt,
  output logic    busy,
  output logic    mdc,
  output logic    done,
  output strobe_t stb
);

  localparam int PW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HALF = CLK_DIV / 2;
  localparam logic [PW-1:0] PH_LAST = PW'(CLK_DIV - 1);
  localparam logic [PW-1:0] PH_HIGH = PW'(HALF);
  localparam logic [PW-1:0] PH_EXT  = PW'(HALF - 1);

  ctrlState_t state;
  logic [PW-1:0] ph;
  logic [SLOT_W-1:0] slotCnt;
  logic isWrite;
  logic detPending;

  logic slotEnd;
  logic [SLOT_W-1:0] lastSlot;
  logic inRdWindow;
  logic [PW-1:0] samplePh;

  assign slotEnd    = (ph == PH_LAST);
  assign lastSlot   = isWrite ? SLOT_W'(WR_SLOTS - 1) : SLOT_W'(RD_SLOTS - 1);
  assign inRdWindow = (slotCnt >= SLOT_W'(RD_DATA_FIRST)) &&
                      (slotCnt <  SLOT_W'(RD_DATA_FIRST + DATA_BITS));
  assign samplePh   = portExt ? PH_EXT : PH_LAST;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_PRE;
      ph         <= '0;
      slotCnt    <= '0;
      isWrite    <= 1'b0;
      detPending <= 1'b1;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_RDY) begin
        ph <= '0;
        if (reqValid) begin
          if (noTcvr) begin
            done <= 1'b1;
          end else begin
            state   <= ST_PRE;
            isWrite <= reqWrite;
            slotCnt <= '0;
          end
        end
      end else begin
        ph <= slotEnd ? '0 : ph + 1'b1;
        if (slotEnd) begin
          unique case (state)
            ST_PRE: begin
              if (slotCnt == SLOT_W'(PRE_SLOTS - 1)) begin
                slotCnt <= '0;
                state   <= detPending ? ST_DET : ST_BITS;
              end else begin
                slotCnt <= slotCnt + 1'b1;
              end
            end
            ST_DET: begin
              detPending <= 1'b0;
              state      <= ST_RDY;
            end
            ST_BITS: begin
              if (slotCnt == lastSlot) begin
                state <= ST_RDY;
                done  <= 1'b1;
              end else begin
                slotCnt <= slotCnt + 1'b1;
              end
            end
            default: state <= ST_RDY;
          endcase
        end
      end
    end
  end

  always_comb begin
    stb           = '0;
    stb.loadFrame = (state == ST_RDY) && reqValid && !noTcvr;
    stb.finishBad = (state == ST_RDY) && reqValid && noTcvr;
    stb.shiftTx   = (state == ST_BITS) && slotEnd;
    stb.sampleRx  = (state == ST_BITS) && !isWrite && inRdWindow && (ph == samplePh);
    stb.sampleDet = (state == ST_DET) && slotEnd;
    stb.finishRd  = (state == ST_BITS) && slotEnd && !isWrite &&
                    (slotCnt == SLOT_W'(RD_SLOTS - 1));
    stb.driveBoth = (state == ST_PRE);
    stb.driveAct  = (state == ST_BITS) &&
                    (isWrite || (slotCnt < SLOT_W'(RD_HDR_SLOTS)));
  end

  assign busy = (state != ST_RDY);
  assign mdc  = busy && (ph >= PH_HIGH);

endmodule

// File: rtl/mdio_dm_dpath.sv
module mdio_dm_dpath
  import mdio_dm_pkg::*;
#(
  parameter logic [4:0] INT_ADDR = 5'h01,
  parameter logic [4:0] EXT_ADDR = 5'h00
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        stb,
  input  logic           reqWrite,
  input  logic [4:0]     reqReg,
  input  logic [DATA_BITS-1:0] reqData,
  input  logic           intMdi,
  input  logic           extMdi,
  output logic           intMdo,
  output logic           intMdoEn,
  output logic           extMdo,
  output logic           extMdoEn,
  output logic [DATA_BITS-1:0] rdData,
  output logic           invalid,
  output logic           portExt,
  output logic           noTcvr
);

  localparam int TX_W = WR_SLOTS;

  logic [TX_W-1:0] txSh;
  logic [DATA_BITS-1:0] rxSh;
  logic [4:0] busAddr;
  logic [1:0] lineIn;
  logic [1:0] lineOut;
  logic [1:0] lineOe;

  assign busAddr = portExt ? EXT_ADDR : INT_ADDR;
  assign lineIn  = {extMdi, intMdi};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh    <= '1;
      rxSh    <= '0;
      rdData  <= '0;
      invalid <= 1'b0;
      portExt <= 1'b0;
      noTcvr  <= 1'b0;
    end else begin
      invalid <= stb.finishBad;
      if (stb.loadFrame) begin
        if (reqWrite) txSh <= {4'b0101, busAddr, reqReg, 2'b10, reqData};
        else          txSh <= {4'b0110, busAddr, reqReg, 18'h3FFFF};
      end else if (stb.shiftTx) begin
        txSh <= {txSh[TX_W-2:0], 1'b1};
      end
      if (stb.sampleRx) rxSh <= {rxSh[DATA_BITS-2:0], lineIn[portExt]};
      if (stb.finishRd)  rdData <= rxSh;
      if (stb.finishBad) rdData <= '1;
      if (stb.sampleDet) begin
        if (extMdi) begin
          portExt <= 1'b1;
          noTcvr  <= 1'b0;
        end else if (intMdi) begin
          portExt <= 1'b0;
          noTcvr  <= 1'b0;
        end else begin
          portExt <= 1'b0;
          noTcvr  <= 1'b1;
        end
      end
    end
  end

  // index 0: on-board line, index 1: plug-in line
  for (genvar g = 0; g < 2; g++) begin : g_line
    logic isAct;
    assign isAct      = (g == 1) ? portExt : !portExt;
    assign lineOe[g]  = stb.driveBoth || (stb.driveAct && isAct);
    assign lineOut[g] = (stb.driveAct && isAct) ? txSh[TX_W-1] : 1'b1;
  end

  assign intMdo   = lineOut[0];
  assign intMdoEn = lineOe[0];
  assign extMdo   = lineOut[1];
  assign extMdoEn = lineOe[1];

endmodule

// File: rtl/mdio_dual_master.sv
module mdio_dual_master
  import mdio_dm_pkg::*;
#(
  parameter int         CLK_DIV  = 4,
  parameter logic [4:0] INT_ADDR = 5'h01,
  parameter logic [4:0] EXT_ADDR = 5'h00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [4:0]  reqReg,
  input  logic [15:0] reqData,
  output logic        busy,
  output logic        done,
  output logic        invalid,
  output logic [15:0] rdData,
  output logic        portExt,
  output logic        noTcvr,
  output logic        mdc,
  input  logic        intMdi,
  output logic        intMdo,
  output logic        intMdoEn,
  input  logic        extMdi,
  output logic        extMdo,
  output logic        extMdoEn
);

  strobe_t stb;

  mdio_dm_ctrl #(
    .CLK_DIV(CLK_DIV)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .noTcvr  (noTcvr),
    .portExt (portExt),
    .busy    (busy),
    .mdc     (mdc),
    .done    (done),
    .stb     (stb)
  );

  mdio_dm_dpath #(
    .INT_ADDR(INT_ADDR),
    .EXT_ADDR(EXT_ADDR)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqWrite(reqWrite),
    .reqReg  (reqReg),
    .reqData (reqData),
    .intMdi  (intMdi),
    .extMdi  (extMdi),
    .intMdo  (intMdo),
    .intMdoEn(intMdoEn),
    .extMdo  (extMdo),
    .extMdoEn(extMdoEn),
    .rdData  (rdData),
    .invalid (invalid),
    .portExt (portExt),
    .noTcvr  (noTcvr)
  );

endmodule

// File: rtl/mdio_dual_master_chk.sv
module mdio_dual_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic        invalid,
  input logic [15:0] rdData,
  input logic        mdc,
  input logic        intMdoEn,
  input logic        extMdoEn
);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: busy is already low when done is seen
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9: the result register moves only with done
  p_rd_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> done);

  // R3: clock is parked low when idle
  p_mdc_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  // R3: each clock half lasts at least two system cycles
  p_mdc_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |=> mdc);
  p_mdc_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mdc) |=> !mdc);

  // R8: no line is driven while idle
  p_released_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!intMdoEn && !extMdoEn));

  // R10: a refused request reports all ones with done
  p_invalid_r10: assert property (@(posedge clk) disable iff (!rstN)
    invalid |-> (done && rdData == 16'hFFFF));

endmodule

bind mdio_dual_master mdio_dual_master_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .done    (done),
  .invalid (invalid),
  .rdData  (rdData),
  .mdc     (mdc),
  .intMdoEn(intMdoEn),
  .extMdoEn(extMdoEn)
);

// File: tb/mdio_dual_master_bench.sv
module mdio_dual_master_bench;

  localparam int DIV  = 6;
  localparam int HALF = DIV / 2;
  localparam logic [4:0] INT_A = 5'h13;
  localparam logic [4:0] EXT_A = 5'h0A;

  // slot code: [0]intOe [1]intOut [2]extOe [3]extOut [4]data slot [5]data bit [6]probe
  localparam logic [7:0] C_PRE = 8'b0000_1111;
  localparam logic [7:0] C_REL = 8'b0000_1010;
  localparam logic [7:0] C_DET = 8'b0100_1010;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [4:0] reqReg = '0;
  logic [15:0] reqData = '0;
  logic intMdi = 1'b1, extMdi = 1'b1;
  logic busy, done, invalid, portExt, noTcvr, mdc;
  logic [15:0] rdData;
  logic intMdo, intMdoEn, extMdo, extMdoEn;

  mdio_dual_master #(
    .CLK_DIV (DIV),
    .INT_ADDR(INT_A),
    .EXT_ADDR(EXT_A)
  ) u_mdio_dual_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReg(reqReg), .reqData(reqData), .busy(busy), .done(done),
    .invalid(invalid), .rdData(rdData), .portExt(portExt), .noTcvr(noTcvr),
    .mdc(mdc), .intMdi(intMdi), .intMdo(intMdo), .intMdoEn(intMdoEn),
    .extMdi(extMdi), .extMdo(extMdo), .extMdoEn(extMdoEn)
  );

  int checks = 0;
  int fails = 0;

  logic [7:0] slotQ[$];
  string tagQ[$];
  bit mRun;
  int mPh;
  bit mDone, mInv, mPortExt, mNoT;
  int mKind;
  logic [15:0] mRd, pendRd;
  logic [7:0] popped;
  bit detInt, detExt;
  logic [15:0] phyVal = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] drvSlot(input bit ext, input bit b);
    if (ext) return {4'b0000, b, 1'b1, 1'b1, 1'b0};
    return {4'b0000, 1'b1, 1'b0, b, 1'b1};
  endfunction

  task automatic pushFrame(input bit wr, input logic [4:0] rg,
                           input logic [15:0] dat, input logic [15:0] rv);
    logic [4:0] ad;
    logic [31:0] bits;
    ad = mPortExt ? EXT_A : INT_A;
    for (int i = 0; i < 20; i++) begin slotQ.push_back(C_PRE); tagQ.push_back("R4"); end
    if (wr) begin
      bits = {4'b0101, ad, rg, 2'b10, dat};
      for (int i = 31; i >= 0; i--) begin
        slotQ.push_back(drvSlot(mPortExt, bits[i])); tagQ.push_back("R6");
      end
    end else begin
      bits = {4'b0110, ad, rg, 18'h0};
      for (int i = 31; i >= 18; i--) begin
        slotQ.push_back(drvSlot(mPortExt, bits[i])); tagQ.push_back("R5");
      end
      for (int i = 0; i < 2; i++) begin slotQ.push_back(C_REL); tagQ.push_back("R8"); end
      for (int i = 15; i >= 0; i--) begin
        slotQ.push_back(8'b0001_1010 | (8'(rv[i]) << 5)); tagQ.push_back("R7");
      end
      for (int i = 0; i < 3; i++) begin slotQ.push_back(C_REL); tagQ.push_back("R8"); end
    end
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      slotQ.delete(); tagQ.delete();
      for (int i = 0; i < 20; i++) begin slotQ.push_back(C_PRE); tagQ.push_back("R1"); end
      slotQ.push_back(C_DET); tagQ.push_back("R1");
      mRun = 1; mPh = 0; mDone = 0; mInv = 0; mRd = '0;
      mPortExt = 0; mNoT = 0; mKind = 0;
    end else begin
      mDone = 0; mInv = 0;
      if (mRun) begin
        if (mPh == DIV - 1) begin
          mPh = 0;
          popped = slotQ.pop_front();
          void'(tagQ.pop_front());
          if (popped[6]) begin
            if (detExt) begin mPortExt = 1; mNoT = 0; end
            else if (detInt) begin mPortExt = 0; mNoT = 0; end
            else begin mPortExt = 0; mNoT = 1; end
          end
          if (slotQ.size() == 0) begin
            mRun = 0;
            if (mKind != 0) mDone = 1;
            if (mKind == 2) mRd = pendRd;
          end
        end else begin
          mPh++;
        end
      end else if (reqValid) begin
        if (mNoT) begin
          mDone = 1; mInv = 1; mRd = 16'hFFFF;
        end else begin
          pushFrame(reqWrite, reqReg, reqData, phyVal);
          mRun = 1; mPh = 0;
          mKind = reqWrite ? 1 : 2;
          pendRd = phyVal;
        end
      end
    end
  end

  // per-cycle comparison and transceiver response, away from the active edge
  always @(negedge clk) begin
    logic [7:0] ec;
    string et;
    bit b, win;
    ec = mRun ? slotQ[0] : C_REL;
    et = mRun ? tagQ[0] : "R8";
    if (rstN) begin
      chk(mdc == (mRun && mPh >= HALF), "R3", "mdc", mdc, (mRun && mPh >= HALF));
      chk(intMdoEn == ec[0], et, "intMdoEn", intMdoEn, ec[0]);
      chk(intMdo == ec[1], et, "intMdo", intMdo, ec[1]);
      chk(extMdoEn == ec[2], et, "extMdoEn", extMdoEn, ec[2]);
      chk(extMdo == ec[3], et, "extMdo", extMdo, ec[3]);
      chk(busy == mRun, "R9", "busy", busy, mRun);
      chk(done == mDone, "R9", "done", done, mDone);
      chk(portExt == mPortExt, "R2", "portExt", portExt, mPortExt);
      chk(noTcvr == mNoT, "R2", "noTcvr", noTcvr, mNoT);
      if (mDone) begin
        chk(invalid == mInv, "R10", "invalid", invalid, mInv);
        chk(rdData == mRd, "R7", "rdData", rdData, mRd);
      end
    end
    intMdi = 1'b1;
    extMdi = 1'b1;
    if (mRun && ec[6]) begin
      intMdi = detInt;
      extMdi = detExt;
    end else if (mRun && ec[4]) begin
      b = ec[5];
      win = mPortExt ? (mPh < HALF) : (mPh >= HALF);
      if (mPortExt) extMdi = win ? b : ~b;
      else          intMdi = win ? b : ~b;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic doReset(input bit di, input bit de);
    @(negedge clk);
    detInt = di; detExt = de;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic req(input bit wr, input logic [4:0] rg,
                     input logic [15:0] dat, input logic [15:0] rv);
    @(negedge clk);
    phyVal = rv; reqWrite = wr; reqReg = rg; reqData = dat; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic readCheck(input logic [4:0] rg, input logic [15:0] rv);
    req(1'b0, rg, 16'h0, rv);
    waitIdle();
    chk(done == 1'b1, "R9", "done at end of read", done, 1);
    chk(rdData == rv, "R7", "read result", rdData, rv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    // scenario 1: both lines answer the probe, plug-in wins
    doReset(1'b1, 1'b1);
    chk(busy == 1'b1, "R1", "busy after reset", busy, 1);
    chk(intMdoEn && extMdoEn && intMdo && extMdo, "R1", "preamble drive",
        {intMdoEn, extMdoEn, intMdo, extMdo}, 4'hF);
    chk(mdc == 1'b0, "R3", "mdc at slot start", mdc, 0);
    req(1'b1, 5'h07, 16'h1234, 16'h0);   // ignored during probe (R1)
    waitIdle();
    chk(portExt == 1'b1 && noTcvr == 1'b0, "R2", "plug-in priority",
        {portExt, noTcvr}, 2'b10);
    chk(done == 1'b0, "R1", "no frame from early request", done, 0);
    req(1'b1, 5'h1B, 16'hA53C, 16'h0);
    waitIdle();
    chk(rdData == 16'h0, "R9", "write leaves result", rdData, 0);
    readCheck(5'h02, 16'h9C61);
    readCheck(5'h1F, 16'h0000);
    // request while busy (R11)
    req(1'b0, 5'h04, 16'h0, 16'hC3A5);
    repeat (60) @(negedge clk);
    reqWrite = 1'b1; reqReg = 5'h11; reqData = 16'hFFFF; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    waitIdle();
    chk(rdData == 16'hC3A5, "R7", "read after ignored request", rdData, 16'hC3A5);
    @(negedge clk);
    chk(busy == 1'b0, "R11", "no second frame", busy, 0);

    // scenario 2: only the on-board line answers
    doReset(1'b1, 1'b0);
    waitIdle();
    chk(portExt == 1'b0 && noTcvr == 1'b0, "R2", "on-board selected",
        {portExt, noTcvr}, 2'b00);
    req(1'b1, 5'h00, 16'h8001, 16'h0);
    waitIdle();
    readCheck(5'h15, 16'h5AA5);
    readCheck(5'h0C, 16'h8001);

    // scenario 3: nothing answers
    doReset(1'b0, 1'b0);
    waitIdle();
    chk(noTcvr == 1'b1 && portExt == 1'b0, "R2", "no transceiver",
        {portExt, noTcvr}, 2'b01);
    req(1'b0, 5'h01, 16'h0, 16'h1111);
    chk(done && invalid, "R10", "immediate refusal", {done, invalid}, 2'b11);
    chk(rdData == 16'hFFFF, "R10", "all ones", rdData, 16'hFFFF);
    chk(!intMdoEn && !extMdoEn && !mdc, "R10", "lines quiet",
        {intMdoEn, extMdoEn, mdc}, 0);
    req(1'b1, 5'h03, 16'h2222, 16'h0);
    chk(done && invalid, "R10", "write refused", {done, invalid}, 2'b11);
    repeat (4) @(negedge clk);

    summary();
    $finish;
  end

endmodule